// File: doc/BRIEF.md
# Strip-Mined Vector Length Sequencer

This block splits a loop over an arbitrary number of elements into pieces that a vector unit of fixed maximum length can process. A single pulse on `start_i` loads the element total. The block then presents one piece at a time, giving its first element index and its length. It keeps each piece on its outputs until the vector unit acknowledges it, then moves on to the next.

The piece whose size is not a whole multiple of the maximum length is issued first. Every later piece is full length. Each new first index is the previous one plus the length just consumed, so the index always lands on a piece boundary. When every element has been handed out, a finished flag rises and stays high until the next start. A total of zero gives no pieces at all.

The maximum vector length `MVL` is a parameter with a default of 64. The element total is `N_W` bits wide, with a default of 16.

Top module: `vls_seq`

## Requirements
- R1: During and after a synchronous active-low reset, `chunk_valid_o` and `finished_o` are both 0.
- R2: For a nonzero total n whose remainder n mod MVL is nonzero, the first piece appears on the cycle after the accepted start. It has `chunk_base_o` = 0 and `chunk_len_o` = n mod MVL.
- R3: For a nonzero total that is an exact multiple of MVL, no zero-length piece is issued. The first piece has base 0 and length MVL.
- R4: Every piece after the first has length MVL. Its base equals the previous base plus the previous length. It appears on the cycle after the done that closed the previous piece.
- R5: While `chunk_valid_o` is 1 and `chunk_done_i` is 0, the valid, base and length outputs stay unchanged into the next cycle.
- R6: The number of pieces issued is ceil(n/MVL), and their lengths add up to n. On the cycle after the done of the last piece, `chunk_valid_o` is 0 and `finished_o` is 1.
- R7: For a total of zero, `finished_o` is 1 on the cycle after the start and no piece is issued.
- R8: A start while pieces are still outstanding is ignored. A done while `chunk_valid_o` is 0 has no effect.
- R9: `finished_o` stays 1 until a start is accepted. A start accepted in the finished state begins a new sequence from base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Pulse that loads `total_i` and begins a sequence |
| total_i | input | N_W | Total element count, sampled with `start_i` |
| chunk_done_i | input | 1 | Vector unit has consumed the presented piece |
| chunk_valid_o | output | 1 | A piece is being presented |
| chunk_base_o | output | N_W | First element index of the piece |
| chunk_len_o | output | $clog2(MVL+1) | Length of the piece |
| finished_o | output | 1 | All elements have been issued |

## Verification
The assertions check the following on every cycle:
- a presented length is never zero and never above MVL;
- a piece that is not acknowledged stays unchanged;
- each step after a done advances the base by the length just consumed, or else ends the sequence;
- valid and finished are never both high;
- the finished flag only rises after a last done or after a zero-total start.

Some properties need a whole sequence and are shown only by the bench scenarios, which compare every cycle against a queue-based model:
- the remainder-first ordering;
- the skipping of an empty remainder;
- the exact number of pieces and the total of their lengths;
- that a start while busy and a stray done change nothing.

// File: rtl/vls_pkg.sv
// Package: shared types for the strip-mined vector length sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package vls_pkg;

    // Sequencer phase: waiting, issuing pieces, all pieces handed out.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } vls_phase_e;

endpackage

// File: rtl/vls_head_len.sv
// Module: vls_head_len
// Works out the length of the first piece and the number of elements left
// after it, for a total n. The first piece is n mod MVL, or MVL when that
// remainder is zero (an empty piece is never issued).
// Assumes MVL >= 1 and MVL fits in N_W bits. When MVL is a power of two, a
// mask replaces the modulo.
module vls_head_len #(
    parameter int MVL   = 64,
    parameter int N_W   = 16,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input  logic [N_W-1:0]   total_i,
    output logic             zero_o,
    output logic [LEN_W-1:0] head_len_o,
    output logic [N_W-1:0]   tail_o
);

    localparam logic [N_W-1:0] MVL_N    = N_W'(MVL);
    localparam bit             MVL_POW2 = ((MVL & (MVL - 1)) == 0);

    logic [N_W-1:0] rem_n;
    logic [N_W-1:0] head_n;

    // Remainder variant picked by whether MVL is a power of two.
    generate
        if (MVL_POW2) begin : g_mask
            // Remainder by masking the low bits.
            always_comb rem_n = total_i & N_W'(MVL - 1);
        end else begin : g_mod
            // Remainder by a general modulo.
            always_comb rem_n = total_i % MVL_N;
        end
    endgenerate

    // First piece length, with an empty remainder replaced by a full piece.
    always_comb begin
        zero_o     = (total_i == '0);
        head_n     = (rem_n == '0) ? MVL_N : rem_n;
        head_len_o = LEN_W'(head_n);
        tail_o     = zero_o ? '0 : (total_i - head_n);
    end

endmodule

// File: rtl/vls_phase_ctrl.sv
// Module: vls_phase_ctrl
// Phase register of the sequencer. A start is accepted only outside the
// issuing phase. A zero total goes straight to the finished phase. A done on
// the last piece ends the issuing phase.
// Assumes a synchronous active-low reset.
module vls_phase_ctrl
    import vls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       total_zero_i,
    input  logic       done_i,
    input  logic       last_i,
    output logic       accept_o,
    output logic       step_o,
    output vls_phase_e phase_o
);

    vls_phase_e phase_q;
    vls_phase_e phase_d;

    // Accept and step qualifiers derived from the current phase.
    always_comb begin
        accept_o = start_i && (phase_q != PH_RUN);
        step_o   = done_i && (phase_q == PH_RUN);
    end

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        if (accept_o) begin
            phase_d = total_zero_i ? PH_FIN : PH_RUN;
        end else if (step_o && last_i) begin
            phase_d = PH_FIN;
        end
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/vls_cursor.sv
// Module: vls_cursor
// Holds the presented piece (base, length) and the elements still to be
// issued after it. On accept it loads the first piece. On a non-final step it
// advances the base by the current length and switches to full MVL pieces.
// Assumes the remaining count after the first piece is a multiple of MVL.
module vls_cursor #(
    parameter int MVL   = 64,
    parameter int N_W   = 16,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             step_i,
    input  logic [LEN_W-1:0] head_len_i,
    input  logic [N_W-1:0]   tail_i,
    output logic [N_W-1:0]   base_o,
    output logic [LEN_W-1:0] len_o,
    output logic             last_o
);

    localparam logic [N_W-1:0]   MVL_N = N_W'(MVL);
    localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

    logic [N_W-1:0]   base_q;
    logic [LEN_W-1:0] len_q;
    logic [N_W-1:0]   left_q;

    // Piece registers: load on accept, advance on a non-final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            left_q <= '0;
        end else if (accept_i) begin
            base_q <= '0;
            len_q  <= head_len_i;
            left_q <= tail_i;
        end else if (step_i && !last_o) begin
            base_q <= base_q + N_W'(len_q);
            len_q  <= MVL_L;
            left_q <= left_q - MVL_N;
        end
    end

    // The presented piece is the last one when nothing remains behind it.
    always_comb last_o = (left_q == '0);

    assign base_o = base_q;
    assign len_o  = len_q;

endmodule

// File: rtl/vls_seq.sv
// Module: vls_seq (top)
// Strip-mined vector length sequencer. It issues the remainder piece first,
// then full MVL pieces, each held until chunk_done_i. It then raises
// finished_o, which holds until the next accepted start.
// Assumes chunk_done_i is looked at only while chunk_valid_o is high.
module vls_seq
    import vls_pkg::*;
#(
    parameter int MVL   = 64,
    parameter int N_W   = 16,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [N_W-1:0]   total_i,
    input  logic             chunk_done_i,
    output logic             chunk_valid_o,
    output logic [N_W-1:0]   chunk_base_o,
    output logic [LEN_W-1:0] chunk_len_o,
    output logic             finished_o
);

    logic             total_zero;
    logic [LEN_W-1:0] head_len;
    logic [N_W-1:0]   tail;
    logic             accept;
    logic             step;
    logic             last;
    vls_phase_e       phase;

    vls_head_len #(.MVL(MVL), .N_W(N_W), .LEN_W(LEN_W)) u_head (
        .total_i    (total_i),
        .zero_o     (total_zero),
        .head_len_o (head_len),
        .tail_o     (tail)
    );

    vls_phase_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .total_zero_i (total_zero),
        .done_i       (chunk_done_i),
        .last_i       (last),
        .accept_o     (accept),
        .step_o       (step),
        .phase_o      (phase)
    );

    vls_cursor #(.MVL(MVL), .N_W(N_W), .LEN_W(LEN_W)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .step_i     (step),
        .head_len_i (head_len),
        .tail_i     (tail),
        .base_o     (chunk_base_o),
        .len_o      (chunk_len_o),
        .last_o     (last)
    );

    // Output flags decoded from the phase.
    always_comb begin
        chunk_valid_o = (phase == PH_RUN);
        finished_o    = (phase == PH_FIN);
    end

endmodule

// File: rtl/vls_seq_chk.sv
// Module: vls_seq_chk
// Cycle-level properties of vls_seq, attached through bind.
module vls_seq_chk #(
    parameter int MVL   = 64,
    parameter int N_W   = 16,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [N_W-1:0]   total_i,
    input logic             chunk_done_i,
    input logic             chunk_valid_o,
    input logic [N_W-1:0]   chunk_base_o,
    input logic [LEN_W-1:0] chunk_len_o,
    input logic             finished_o
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!chunk_valid_o && !finished_o));

    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid_o |-> (chunk_len_o != '0 && chunk_len_o <= LEN_W'(MVL)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid_o && !chunk_done_i) |=>
        (chunk_valid_o && $stable(chunk_base_o) && $stable(chunk_len_o)));

    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid_o && chunk_done_i) |=>
        (finished_o || (chunk_valid_o && chunk_len_o == LEN_W'(MVL) &&
         chunk_base_o == $past(chunk_base_o) + N_W'($past(chunk_len_o)))));

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(chunk_valid_o && finished_o));

    p_fin_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(finished_o) |->
        ($past(chunk_valid_o && chunk_done_i) || $past(start_i && total_i == '0)));

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid_o && !chunk_done_i && start_i) |=>
        (chunk_valid_o && $stable(chunk_base_o)));

    p_fin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (finished_o && !start_i) |=> finished_o);

endmodule

bind vls_seq vls_seq_chk #(.MVL(MVL), .N_W(N_W), .LEN_W(LEN_W)) u_vls_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .total_i       (total_i),
    .chunk_done_i  (chunk_done_i),
    .chunk_valid_o (chunk_valid_o),
    .chunk_base_o  (chunk_base_o),
    .chunk_len_o   (chunk_len_o),
    .finished_o    (finished_o)
);

// File: tb/vls_seq_bench.sv
// Bench for vls_seq: queue-based reference model compared every cycle.
module vls_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MVL   = 64;
    localparam int N_W   = 16;
    localparam int LEN_W = $clog2(MVL + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [N_W-1:0]   total_i = '0;
    logic             chunk_done_i = 1'b0;
    logic             chunk_valid_o;
    logic [N_W-1:0]   chunk_base_o;
    logic [LEN_W-1:0] chunk_len_o;
    logic             finished_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Reference model state.
    int  m_q[$];
    int  m_base = 0;
    bit  m_busy = 0;
    bit  m_fin = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vls_seq #(.MVL(MVL), .N_W(N_W), .LEN_W(LEN_W)) u_vls_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .total_i       (total_i),
        .chunk_done_i  (chunk_done_i),
        .chunk_valid_o (chunk_valid_o),
        .chunk_base_o  (chunk_base_o),
        .chunk_len_o   (chunk_len_o),
        .finished_o    (finished_o)
    );

    // Model update: remainder piece first, then full pieces.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_base = 0; m_busy = 0; m_fin = 0;
        end else if (!m_busy) begin
            if (start_i) begin
                int n;
                n = int'(total_i);
                m_q.delete();
                m_base = 0;
                if (n % MVL != 0) m_q.push_back(n % MVL);
                for (int k = 0; k < n / MVL; k++) m_q.push_back(MVL);
                m_busy = (m_q.size() != 0);
                m_fin  = (m_q.size() == 0);
            end
        end else if (chunk_done_i) begin
            m_base = m_base + m_q[0];
            void'(m_q.pop_front());
            if (m_q.size() == 0) begin
                m_busy = 0; m_fin = 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare();
        check(cur_req, "valid", int'(chunk_valid_o), int'(m_busy));
        check(cur_req, "finished", int'(finished_o), int'(m_fin));
        if (m_busy && chunk_valid_o) begin
            check(cur_req, "base", int'(chunk_base_o), m_base);
            check(cur_req, "len", int'(chunk_len_o), m_q[0]);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    // Run one sequence, acknowledging on every stall_mod-th cycle.
    task automatic run_seq(input int n, input int stall_mod, input string req, input bit poke_start);
        int pieces = 0;
        int sum = 0;
        int cyc = 0;
        cur_req = req;
        start_i = 1'b1; total_i = N_W'(n);
        tick();
        start_i = 1'b0;
        while (!finished_o && cyc < 5000) begin
            chunk_done_i = chunk_valid_o && ((cyc % stall_mod) == 0);
            // R8: start while busy must be ignored.
            start_i = poke_start && chunk_valid_o && (cyc == 1);
            total_i = poke_start ? N_W'(7) : N_W'(n);
            if (chunk_done_i) begin
                pieces++;
                sum += int'(chunk_len_o);
            end
            tick();
            cyc++;
        end
        chunk_done_i = 1'b0; start_i = 1'b0;
        check("R6", "piece count", pieces, (n + MVL - 1) / MVL);
        check("R6", "length sum", sum, n);
    endtask

    initial begin
        rst_n = 1'b0;
        tick();
        tick();
        // R1: reset state.
        check("R1", "valid in reset", int'(chunk_valid_o), 0);
        check("R1", "finished in reset", int'(finished_o), 0);
        rst_n = 1'b1;
        tick();
        check("R1", "valid after reset", int'(chunk_valid_o), 0);

        // R7: zero total.
        cur_req = "R7";
        start_i = 1'b1; total_i = '0;
        tick();
        start_i = 1'b0;
        check("R7", "finished after zero start", int'(finished_o), 1);
        check("R7", "no piece on zero", int'(chunk_valid_o), 0);

        // R9: finished holds while idle; stray done ignored (R8).
        cur_req = "R9";
        tick();
        check("R9", "finished holds", int'(finished_o), 1);
        cur_req = "R8";
        chunk_done_i = 1'b1;
        tick();
        chunk_done_i = 1'b0;
        check("R8", "stray done", int'(finished_o), 1);

        // R2: short total, remainder only.
        run_seq(5, 1, "R2", 1'b0);
        // R3: exact multiple, no empty piece.
        run_seq(128, 2, "R3", 1'b0);
        // R4: remainder then full pieces, with stalls (R5).
        run_seq(130, 3, "R4", 1'b0);
        run_seq(64, 4, "R5", 1'b0);
        // R8: start during the sequence is ignored.
        run_seq(200, 2, "R8", 1'b1);
        // R9: restart from finished, large total.
        run_seq(65535, 1, "R9", 1'b0);
        run_seq(1, 1, "R2", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule